// File: doc/BRIEF.md
# Card SPI Command Frame Engine

This block issues one command to a memory card that is driven in SPI mode, and hands back the card's one-byte status reply. A requester supplies a 6-bit command index, a 32-bit argument and a keep-selected flag through a valid/ready port. The engine pulls chip select low and clocks one filler byte. It then sends the six-byte command frame and polls the card with filler bytes until a reply byte with its top bit clear appears. The engine does not shift bits itself. It drives a byte-wide exchange port of an external SPI shifter, starting one byte at a time and waiting for that byte's done strobe.

For the interface-condition command (index 8) and the read-operating-conditions command (index 58), the engine clocks four more bytes and packs them into a 32-bit word. In normal mode it then releases chip select and clocks one more filler byte. In keep-selected mode it reports with chip select still low, so that a data-block phase can follow on the same shifter. If no reply arrives within the poll limit, the engine reports a timeout flag instead of a status value, and it always releases chip select in that case.

Top module: `sdcf_engine`

## Requirements
- R1: After reset, reqReady is high, csN is high, and xferStart and rspValid are low. reqReady is high only while the engine is idle.
- R2: When a request is accepted (reqValid and reqReady high at a clock edge), csN goes low on the next cycle. The first byte exchanged is then 0xFF with csN low, and it comes before any frame byte.
- R3: The next five bytes are 0x40 OR the command index (top two bits 01), followed by the argument bytes from bits 31:24 down to bits 7:0, all with csN low.
- R4: The sixth frame byte is 0x87 when the command index is 8, and 0x95 for every other index.
- R5: After the frame, the engine sends 0xFF bytes with csN low. It stops at the first received byte whose bit 7 is 0 and returns all eight bits of that byte on rspStatus, with rspTimeout low.
- R6: If POLL_LIMIT (default 5000) poll bytes all return bit 7 set, the engine sends no further poll byte. It reports rspTimeout high with rspStatus 0xFF. A reply that arrives on the last allowed poll is still accepted.
- R7: For command indices 8 and 58, four more 0xFF bytes follow the status byte. Their received values form rspWord, with the first byte in bits 31:24. For all other indices no trailing bytes are sent and rspWord is 0. On a timeout rspWord is 0.
- R8: In normal mode, csN is high before the closing 0xFF byte starts. That byte is exchanged with csN high, and rspValid follows after it.
- R9: In keep-selected mode, when a status byte is found, rspValid is raised with csN still low and no closing byte is sent. csN stays low until the next request. A timeout in this mode still raises csN and sends the closing byte.
- R10: rspValid is a single-cycle pulse. reqReady is low from the accepting edge until the cycle after rspValid, and xferStart is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Command request present |
| reqReady | output | 1 | Engine idle and able to accept a request |
| reqCmd | input | 6 | Command index |
| reqArg | input | 32 | Command argument |
| reqHold | input | 1 | Keep-selected mode: leave chip select low after a good reply |
| csN | output | 1 | Card chip select, active low |
| xferStart | output | 1 | One-cycle strobe that starts a byte exchange |
| xferTx | output | 8 | Byte to send, valid from xferStart until xferDone |
| xferRx | input | 8 | Byte received, valid with xferDone |
| xferDone | input | 1 | Byte exchange finished |
| rspValid | output | 1 | One-cycle result strobe |
| rspStatus | output | 8 | Status reply byte, 0xFF on timeout |
| rspWord | output | 32 | Trailing word for indices 8 and 58, else 0 |
| rspTimeout | output | 1 | No reply within the poll limit |

## Verification
The bench goes after the boundaries of the poll loop. It sends a reply on the very last allowed poll, which a design with an off-by-one limit would report as a timeout. It also lets all polls go unanswered, which a design with the opposite error would turn into one extra poll byte. It compares the CRC byte for index 8 and for other indices, and it checks that busy bytes such as 0x80 and 0xFE are skipped while a reply of 0x7E is returned whole. A design that tested the wrong bit, or masked the status, would fail here. Keep-selected runs check that chip select stays low with no closing byte, and that a keep-selected timeout still releases it. Every exchanged byte is matched against an expected chip-select level, so a closing byte sent before chip select rises is caught.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;

  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [7:0] START_BITS = 8'h40;
  localparam logic [7:0] CRC_PLAIN  = 8'h95;
  localparam logic [7:0] CRC_IFCOND = 8'h87;
  localparam logic [5:0] IDX_IFCOND = 6'd8;
  localparam logic [5:0] IDX_OPCOND = 6'd58;
  localparam int         FRAME_LEN  = 6;
  localparam int         TRAIL_LEN  = 4;

  typedef enum logic [0:0] {TX_FILL = 1'b0, TX_FRAME = 1'b1} txSel_e;

  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic   loadReq;
    logic   sendByte;
    txSel_e txSel;
    logic   clrIdx;
    logic   incIdx;
    logic   clrPoll;
    logic   incPoll;
    logic   captureStatus;
    logic   shiftTrail;
    logic   markTimeout;
  } dpStrobe_t;

endpackage

// File: rtl/sdcf_datapath.sv
module sdcf_datapath
  import sdcf_pkg::*;
#(
  parameter int MAX_POLL = 5000,
  parameter int CMD_W    = 6,
  parameter int ARG_W    = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [CMD_W-1:0] reqCmd,
  input  logic [ARG_W-1:0] reqArg,
  input  logic             reqHold,
  input  logic [7:0]       xferRx,
  output logic             xferStart,
  output logic [7:0]       xferTx,
  output logic [7:0]       rspStatus,
  output logic [ARG_W-1:0] rspWord,
  output logic             rspTimeout,
  output logic             frameLast,
  output logic             trailLast,
  output logic             pollLast,
  output logic             needTrail,
  output logic             holdSel,
  output logic             rxTopClear
);

  localparam int POLL_W  = $clog2(MAX_POLL + 1);
  localparam int IDX_W   = $clog2(FRAME_LEN);
  localparam int ARG_BYTES = ARG_W / 8;

  logic [CMD_W-1:0]  cmdReg;
  logic [ARG_W-1:0]  argReg;
  logic              holdReg;
  logic [IDX_W-1:0]  idx;
  logic [POLL_W-1:0] pollCnt;
  logic [7:0]        startReg;
  logic [7:0]        frameByte;

  // Frame byte selection: start byte, argument bytes high first, CRC byte
  always_comb begin
    frameByte = FILL_BYTE;
    if (idx == '0) begin
      frameByte = START_BITS | 8'(cmdReg);
    end else if (int'(idx) == FRAME_LEN - 1) begin
      frameByte = (cmdReg == IDX_IFCOND) ? CRC_IFCOND : CRC_PLAIN;
    end else begin
      for (int b = 1; b <= ARG_BYTES; b++) begin
        if (int'(idx) == b) frameByte = argReg[8*(ARG_BYTES-b) +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg   <= '0;
      argReg   <= '0;
      holdReg  <= 1'b0;
    end else if (stb.loadReq) begin
      cmdReg   <= reqCmd;
      argReg   <= reqArg;
      holdReg  <= reqHold;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
    end else if (stb.clrIdx) begin
      idx <= '0;
    end else if (stb.incIdx) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollCnt <= '0;
    end else if (stb.clrPoll) begin
      pollCnt <= '0;
    end else if (stb.incPoll) begin
      pollCnt <= pollCnt + 1'b1;
    end
  end

  // Byte exchange launch: strobe and byte registered together
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startReg  <= FILL_BYTE;
      xferStart <= 1'b0;
    end else begin
      xferStart <= stb.sendByte;
      if (stb.sendByte) begin
        startReg <= (stb.txSel == TX_FRAME) ? frameByte : FILL_BYTE;
      end
    end
  end

  assign xferTx = startReg;

  // Result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspStatus  <= FILL_BYTE;
      rspWord    <= '0;
      rspTimeout <= 1'b0;
    end else if (stb.loadReq) begin
      rspStatus  <= FILL_BYTE;
      rspWord    <= '0;
      rspTimeout <= 1'b0;
    end else begin
      if (stb.captureStatus) rspStatus <= xferRx;
      if (stb.shiftTrail)    rspWord   <= {rspWord[ARG_W-9:0], xferRx};
      if (stb.markTimeout)   rspTimeout <= 1'b1;
    end
  end

  assign frameLast  = (int'(idx) == FRAME_LEN - 1);
  assign trailLast  = (int'(idx) == TRAIL_LEN - 1);
  assign pollLast   = (pollCnt == POLL_W'(MAX_POLL - 1));
  assign needTrail  = (cmdReg == IDX_IFCOND) || (cmdReg == IDX_OPCOND);
  assign holdSel    = holdReg;
  assign rxTopClear = !xferRx[7];

  // R6
  // poll_bound_chk
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < POLL_W'(MAX_POLL));

  // R10
  // start_gap_chk
  start_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart);

endmodule

// File: rtl/sdcf_ctrl.sv
module sdcf_ctrl
  import sdcf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      xferDone,
  input  logic      frameLast,
  input  logic      trailLast,
  input  logic      pollLast,
  input  logic      needTrail,
  input  logic      holdSel,
  input  logic      rxTopClear,
  output dpStrobe_t stb,
  output logic      reqReady,
  output logic      rspValid,
  output logic      csN
);

  typedef enum logic [3:0] {
    S_IDLE, S_LEAD, S_LEAD_W, S_FRAME, S_FRAME_W, S_POLL, S_POLL_W,
    S_TRAIL, S_TRAIL_W, S_TAIL, S_TAIL_W, S_REPORT
  } state_e;

  state_e state, nextState;
  logic   csNext;

  always_comb begin
    stb       = '0;
    stb.txSel = TX_FILL;
    nextState = state;
    csNext    = csN;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.loadReq = 1'b1;
          csNext      = 1'b0;
          nextState   = S_LEAD;
        end
      end
      S_LEAD: begin
        stb.sendByte = 1'b1;
        nextState    = S_LEAD_W;
      end
      S_LEAD_W: begin
        if (xferDone) begin
          stb.clrIdx = 1'b1;
          nextState  = S_FRAME;
        end
      end
      S_FRAME: begin
        stb.sendByte = 1'b1;
        stb.txSel    = TX_FRAME;
        nextState    = S_FRAME_W;
      end
      S_FRAME_W: begin
        if (xferDone) begin
          if (frameLast) begin
            stb.clrPoll = 1'b1;
            nextState   = S_POLL;
          end else begin
            stb.incIdx = 1'b1;
            nextState  = S_FRAME;
          end
        end
      end
      S_POLL: begin
        stb.sendByte = 1'b1;
        nextState    = S_POLL_W;
      end
      S_POLL_W: begin
        if (xferDone) begin
          if (rxTopClear) begin
            stb.captureStatus = 1'b1;
            if (needTrail) begin
              stb.clrIdx = 1'b1;
              nextState  = S_TRAIL;
            end else if (holdSel) begin
              nextState = S_REPORT;
            end else begin
              csNext    = 1'b1;
              nextState = S_TAIL;
            end
          end else if (pollLast) begin
            stb.markTimeout = 1'b1;
            csNext          = 1'b1;
            nextState       = S_TAIL;
          end else begin
            stb.incPoll = 1'b1;
            nextState   = S_POLL;
          end
        end
      end
      S_TRAIL: begin
        stb.sendByte = 1'b1;
        nextState    = S_TRAIL_W;
      end
      S_TRAIL_W: begin
        if (xferDone) begin
          stb.shiftTrail = 1'b1;
          if (!trailLast) begin
            stb.incIdx = 1'b1;
            nextState  = S_TRAIL;
          end else if (holdSel) begin
            nextState = S_REPORT;
          end else begin
            csNext    = 1'b1;
            nextState = S_TAIL;
          end
        end
      end
      S_TAIL: begin
        stb.sendByte = 1'b1;
        nextState    = S_TAIL_W;
      end
      S_TAIL_W: begin
        if (xferDone) nextState = S_REPORT;
      end
      S_REPORT: nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      csN   <= 1'b1;
    end else begin
      state <= nextState;
      csN   <= csNext;
    end
  end

  assign reqReady = (state == S_IDLE);
  assign rspValid = (state == S_REPORT);

  // R2
  // lead_select_chk
  lead_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> !csN);

  // R10
  // report_pulse_chk
  report_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (reqReady && !rspValid));

  // R8
  // tail_raised_chk
  tail_raised_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TAIL) |-> csN);

endmodule

// File: rtl/sdcf_engine.sv
module sdcf_engine
  import sdcf_pkg::*;
#(
  parameter int MAX_POLL = 5000,
  parameter int CMD_W    = 6,
  parameter int ARG_W    = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [CMD_W-1:0] reqCmd,
  input  logic [ARG_W-1:0] reqArg,
  input  logic             reqHold,
  output logic             csN,
  output logic             xferStart,
  output logic [7:0]       xferTx,
  input  logic [7:0]       xferRx,
  input  logic             xferDone,
  output logic             rspValid,
  output logic [7:0]       rspStatus,
  output logic [ARG_W-1:0] rspWord,
  output logic             rspTimeout
);

  dpStrobe_t stb;
  logic frameLast, trailLast, pollLast, needTrail, holdSel, rxTopClear;

  sdcf_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .xferDone   (xferDone),
    .frameLast  (frameLast),
    .trailLast  (trailLast),
    .pollLast   (pollLast),
    .needTrail  (needTrail),
    .holdSel    (holdSel),
    .rxTopClear (rxTopClear),
    .stb        (stb),
    .reqReady   (reqReady),
    .rspValid   (rspValid),
    .csN        (csN)
  );

  sdcf_datapath #(
    .MAX_POLL (MAX_POLL),
    .CMD_W    (CMD_W),
    .ARG_W    (ARG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reqCmd     (reqCmd),
    .reqArg     (reqArg),
    .reqHold    (reqHold),
    .xferRx     (xferRx),
    .xferStart  (xferStart),
    .xferTx     (xferTx),
    .rspStatus  (rspStatus),
    .rspWord    (rspWord),
    .rspTimeout (rspTimeout),
    .frameLast  (frameLast),
    .trailLast  (trailLast),
    .pollLast   (pollLast),
    .needTrail  (needTrail),
    .holdSel    (holdSel),
    .rxTopClear (rxTopClear)
  );

  // R9
  // timeout_release_chk
  timeout_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspTimeout) |-> csN);

  // R5
  // status_top_chk
  status_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspTimeout) |-> !rspStatus[7]);

  // R1
  // idle_quiet_chk
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!xferStart && !rspValid));

endmodule

// File: tb/sdcf_engine_tb.sv
module sdcf_engine_tb;

  localparam int POLL_LIMIT = 5000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [5:0]  reqCmd = '0;
  logic [31:0] reqArg = '0;
  logic        reqHold = 1'b0;
  logic        csN;
  logic        xferStart;
  logic [7:0]  xferTx;
  logic [7:0]  xferRx = 8'hFF;
  logic        xferDone = 1'b0;
  logic        rspValid;
  logic [7:0]  rspStatus;
  logic [31:0] rspWord;
  logic        rspTimeout;

  always #4 clk = ~clk;

  sdcf_engine u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCmd(reqCmd), .reqArg(reqArg), .reqHold(reqHold), .csN(csN),
    .xferStart(xferStart), .xferTx(xferTx), .xferRx(xferRx),
    .xferDone(xferDone), .rspValid(rspValid), .rspStatus(rspStatus),
    .rspWord(rspWord), .rspTimeout(rspTimeout)
  );

  typedef struct {
    logic [7:0] txb;
    logic       cs;
    string      tag;
  } txItem_t;

  typedef struct {
    logic [7:0]  status;
    logic [31:0] word;
    logic        tmo;
    logic        cs;
    string       tag;
  } rspItem_t;

  txItem_t    expTx[$];
  rspItem_t   expRsp[$];
  logic [7:0] rxQ[$];

  int checks = 0;
  int errors = 0;
  int rspSeen = 0;
  int lat = 1;
  int cycles = 0;
  bit ended = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Shifter model and transfer monitor
  always begin
    @(negedge clk);
    if (xferStart) begin
      if (expTx.size() == 0) begin
        check(0, "R10 unexpected transfer", {23'd0, csN, xferTx}, 32'h0);
      end else begin
        txItem_t e;
        e = expTx.pop_front();
        check((xferTx === e.txb) && (csN === e.cs), e.tag,
              {23'd0, csN, xferTx}, {23'd0, e.cs, e.txb});
      end
      repeat (lat) @(negedge clk);
      xferRx   = (rxQ.size() != 0) ? rxQ.pop_front() : 8'hFF;
      xferDone = 1'b1;
      @(negedge clk);
      xferDone = 1'b0;
    end
  end

  // Result monitor
  logic prevRsp = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (rspValid && prevRsp) check(0, "R10 rspValid wider than one cycle", 32'd1, 32'd0);
      if (rspValid) begin
        if (expRsp.size() == 0) begin
          check(0, "R10 unexpected response", {24'd0, rspStatus}, 32'h0);
        end else begin
          rspItem_t e;
          e = expRsp.pop_front();
          check(rspStatus === e.status, {e.tag, " status"}, {24'd0, rspStatus}, {24'd0, e.status});
          check(rspWord === e.word, {e.tag, " word R7"}, rspWord, e.word);
          check(rspTimeout === e.tmo, {e.tag, " timeout flag"}, {31'd0, rspTimeout}, {31'd0, e.tmo});
          check(csN === e.cs, {e.tag, " csN at result"}, {31'd0, csN}, {31'd0, e.cs});
        end
        rspSeen++;
      end
    end
    prevRsp = rspValid;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 180000) begin
      check(0, "watchdog expired", cycles, 180000);
      finishRun();
    end
  end

  // Driver: build expected traffic and issue one request
  task automatic doCmd(input logic [5:0] cmd, input logic [31:0] arg, input bit hold,
                       input int nBusy, input logic [7:0] r1, input logic [31:0] trail,
                       input bit tmo, input string tag);
    bit trl;
    int tgt;
    logic [7:0] crc;
    trl = (cmd == 6'd8) || (cmd == 6'd58);
    crc = (cmd == 6'd8) ? 8'h87 : 8'h95;
    expTx.push_back('{8'hFF, 1'b0, {tag, " R2 lead byte"}});
    expTx.push_back('{8'h40 | {2'b00, cmd}, 1'b0, {tag, " R3 start byte"}});
    expTx.push_back('{arg[31:24], 1'b0, {tag, " R3 arg byte 1"}});
    expTx.push_back('{arg[23:16], 1'b0, {tag, " R3 arg byte 2"}});
    expTx.push_back('{arg[15:8],  1'b0, {tag, " R3 arg byte 3"}});
    expTx.push_back('{arg[7:0],   1'b0, {tag, " R3 arg byte 4"}});
    expTx.push_back('{crc, 1'b0, {tag, " R4 crc byte"}});
    for (int i = 0; i < 7; i++) rxQ.push_back(8'hFF);
    if (tmo) begin
      for (int i = 0; i < POLL_LIMIT; i++) begin
        expTx.push_back('{8'hFF, 1'b0, {tag, " R6 poll byte"}});
        rxQ.push_back(8'h80 | 8'(i % 128));
      end
    end else begin
      for (int i = 0; i < nBusy; i++) begin
        expTx.push_back('{8'hFF, 1'b0, {tag, " R5 poll byte"}});
        rxQ.push_back((i % 2 == 0) ? 8'h80 : 8'hFE);
      end
      expTx.push_back('{8'hFF, 1'b0, {tag, " R5 reply poll"}});
      rxQ.push_back(r1);
      if (trl) begin
        for (int i = 0; i < 4; i++) begin
          expTx.push_back('{8'hFF, 1'b0, {tag, " R7 trailing byte"}});
          rxQ.push_back(trail[8*(3-i) +: 8]);
        end
      end
    end
    if (!hold || tmo) begin
      expTx.push_back('{8'hFF, 1'b1, {tag, " R8 closing byte"}});
      rxQ.push_back(8'hFF);
    end
    expRsp.push_back('{tmo ? 8'hFF : r1, (trl && !tmo) ? trail : 32'h0, tmo,
                       (hold && !tmo) ? 1'b0 : 1'b1, tag});
    tgt = rspSeen + 1;
    check(reqReady === 1'b1, {tag, " R1 ready before request"}, {31'd0, reqReady}, 32'd1);
    reqCmd = cmd; reqArg = arg; reqHold = hold; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady === 1'b0, {tag, " R10 busy after accept"}, {31'd0, reqReady}, 32'd0);
    wait (rspSeen == tgt);
    @(negedge clk);
    check(expTx.size() == 0, {tag, " R8 all bytes exchanged"}, expTx.size(), 32'd0);
    rxQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(csN === 1'b1, "R1 reset csN", {31'd0, csN}, 32'd1);
    check(reqReady === 1'b1, "R1 reset reqReady", {31'd0, reqReady}, 32'd1);
    check(xferStart === 1'b0, "R1 reset xferStart", {31'd0, xferStart}, 32'd0);
    check(rspValid === 1'b0, "R1 reset rspValid", {31'd0, rspValid}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    lat = 1;
    doCmd(6'd0, 32'h0, 1'b0, 0, 8'h01, 32'h0, 1'b0, "cmd0 R5");
    lat = 3;
    doCmd(6'd17, 32'h12345678, 1'b0, 3, 8'h00, 32'h0, 1'b0, "cmd17 R3");
    lat = 2;
    doCmd(6'd8, 32'h000001AA, 1'b0, 1, 8'h01, 32'h000001AA, 1'b0, "cmd8 R4 R7");
    doCmd(6'd58, 32'h0, 1'b0, 2, 8'h00, 32'hC0FF8000, 1'b0, "cmd58 R7");
    lat = 1;
    doCmd(6'd55, 32'hA5A5F00F, 1'b0, 4, 8'h7E, 32'h0, 1'b0, "cmd55 full status R5");

    // keep-selected: csN must stay low and nothing is exchanged afterwards
    doCmd(6'd24, 32'h00000200, 1'b1, 2, 8'h00, 32'h0, 1'b0, "hold R9");
    repeat (5) @(negedge clk);
    check(csN === 1'b0, "R9 csN still low after hold", {31'd0, csN}, 32'd0);
    doCmd(6'd58, 32'h0, 1'b1, 0, 8'h00, 32'h80FF8000, 1'b0, "hold trailing R9");
    doCmd(6'd13, 32'h0, 1'b0, 0, 8'h00, 32'h0, 1'b0, "normal after hold R8");
    check(csN === 1'b1, "R8 csN high after normal", {31'd0, csN}, 32'd1);

    // reply on the last allowed poll, then full timeouts
    doCmd(6'd41, 32'h40000000, 1'b0, POLL_LIMIT - 1, 8'h00, 32'h0, 1'b0, "last poll R6");
    doCmd(6'd41, 32'h0, 1'b0, 0, 8'h00, 32'h0, 1'b1, "timeout R6");
    doCmd(6'd17, 32'h0000FFFF, 1'b1, 0, 8'h00, 32'h0, 1'b1, "hold timeout R9");
    doCmd(6'd8, 32'h0, 1'b0, 0, 8'h05, 32'h12AB34CD, 1'b0, "cmd8 after timeout R7");

    repeat (4) @(negedge clk);
    check(expRsp.size() == 0, "R10 pending results", expRsp.size(), 32'd0);
    finishRun();
  end

endmodule